// File: doc/BRIEF.md
# Circular Buffer Transfer Count Tracker

This block follows the progress of a circular DMA buffer for one audio stream. The stream can be a playback or a capture stream. The host sets a base count through a small register port and can also set the current count there. Both values are always visible on read ports. When the run enable is raised, the DMA engine pulses a byte strobe for every byte it moves. The block gathers these strobes into groups of four bytes. On each completed group it lowers the current count by one.

When the current count is already zero, the next completed group does not decrement. Instead it reloads the current count from the base count and sets a sticky interrupt flag. The flag stays set until the host acknowledges it. Software therefore programs the base count as (buffer bytes / 4) - 1, which means the buffer length must be a multiple of four bytes.

A system that has both a playback stream and a capture stream uses two copies of this block. Each copy has its own enable, strobe and interrupt.

Top module: `xfer_count_tracker`

## Requirements
- R1: After a synchronous active-low reset, `base_count` and `curr_count` both read 0x0000 and `irq_flag` reads 0.
- R2: While `run_en` is low, a cycle with `wr_base` high loads `wr_data` into both `base_count` and `curr_count`. The new values appear after that clock edge.
- R3: While `run_en` is low, a cycle with `wr_curr` high and `wr_base` low loads `wr_data` into `curr_count` only. `base_count` keeps its value.
- R4: While `run_en` is high, every fourth accepted `byte_stb` lowers `curr_count` by exactly one, provided `curr_count` is nonzero. The first three strobes of a group leave it unchanged.
- R5: If `curr_count` is 0 when a four-byte group completes, `curr_count` is reloaded from `base_count` with no decrement, and `irq_flag` is set.
- R6: While `run_en` is high, `wr_base` and `wr_curr` have no effect on either count.
- R7: Lowering `run_en` discards a partly filled group. After re-enabling, four new strobes are needed for the next step.
- R8: While `run_en` is low, `byte_stb` has no effect on the counts or on `irq_flag`.
- R9: `irq_flag` stays set until a cycle with `irq_ack` high clears it. If a reload event and `irq_ack` fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Enables countdown; host writes ignored while high |
| byte_stb | input | 1 | One pulse per byte moved by the DMA engine |
| wr_base | input | 1 | Host write strobe for the base count (also loads current) |
| wr_curr | input | 1 | Host write strobe for the current count |
| wr_data | input | 16 | Host write data |
| irq_ack | input | 1 | Host acknowledge, clears the interrupt flag |
| base_count | output | 16 | Base count read port |
| curr_count | output | 16 | Current count read port |
| irq_flag | output | 1 | Sticky wrap interrupt |

## Verification
Steady enabled strobing with small base values drives the counter through many wrap-arounds. This separates the decrement path from the reload-at-zero path and shows whether the reload lands one group late, as it should. Strobe bursts that are cut off by dropping the enable show whether a partial group is forgotten or wrongly carried over. Host writes are issued both while disabled and while enabled. These tell an accepted load apart from an ignored one, and tell a base load (both counts) apart from a current-only load. Acknowledges are timed both away from wraps and on the same cycle as a wrap, which checks that the flag is sticky and that setting wins over clearing.

// File: rtl/xct_pkg.sv
// Package: shared types for the transfer count tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package xct_pkg;

    // Action applied to the current count in one cycle.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_DEC    = 2'd1,
        ACT_RELOAD = 2'd2,
        ACT_LOAD   = 2'd3
    } cnt_act_e;

endpackage

// File: rtl/xct_byte_grouper.sv
// Module: xct_byte_grouper
// Gathers byte strobes into groups of GROUP_BYTES and pulses grp_done on
// the strobe that completes a group.
// Assumes: position returns to zero whenever the enable is low.
module xct_byte_grouper #(
    parameter int GROUP_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic byte_stb,
    output logic grp_done
);
    localparam int POS_W = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(GROUP_BYTES - 1);

    generate
        if (GROUP_BYTES == 1) begin : g_single
            // Every enabled strobe completes a group.
            assign grp_done = run_en && byte_stb;
        end else begin : g_multi
            logic [POS_W-1:0] pos_q;

            // Completion pulse on the last byte of a group.
            assign grp_done = run_en && byte_stb && (pos_q == LAST_POS);

            // Track byte position within the current group.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_en) begin
                    pos_q <= '0;
                end else if (byte_stb) begin
                    pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/xct_count_ctrl.sv
// Module: xct_count_ctrl
// Decides the action on the current count each cycle and flags a wrap.
// Assumes: host writes are honoured only while the enable is low; base
// write takes priority over current write.
module xct_count_ctrl
    import xct_pkg::*;
(
    input  logic     run_en,
    input  logic     grp_done,
    input  logic     curr_zero,
    input  logic     wr_base,
    input  logic     wr_curr,
    output cnt_act_e curr_act,
    output logic     base_load,
    output logic     wrap
);
    // Select the current-count action and base load for this cycle.
    always_comb begin
        curr_act  = ACT_HOLD;
        base_load = 1'b0;
        wrap      = 1'b0;
        if (!run_en) begin
            if (wr_base) begin
                base_load = 1'b1;
                curr_act  = ACT_LOAD;
            end else if (wr_curr) begin
                curr_act  = ACT_LOAD;
            end
        end else if (grp_done) begin
            if (curr_zero) begin
                curr_act = ACT_RELOAD;
                wrap     = 1'b1;
            end else begin
                curr_act = ACT_DEC;
            end
        end
    end

endmodule

// File: rtl/xct_count_regs.sv
// Module: xct_count_regs
// Holds the base and current counts and applies the chosen action.
// Assumes: the action and base load come from xct_count_ctrl.
module xct_count_regs
    import xct_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cnt_act_e           curr_act,
    input  logic               base_load,
    input  logic [COUNT_W-1:0] wr_data,
    output logic [COUNT_W-1:0] base_q,
    output logic [COUNT_W-1:0] curr_q,
    output logic               curr_zero
);
    assign curr_zero = (curr_q == '0);

    // Base count register: changes only on an accepted host base write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_load) begin
            base_q <= wr_data;
        end
    end

    // Current count register: load, decrement or reload per action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            curr_q <= '0;
        end else begin
            unique case (curr_act)
                ACT_LOAD:   curr_q <= wr_data;
                ACT_DEC:    curr_q <= curr_q - 1'b1;
                ACT_RELOAD: curr_q <= base_q;
                default:    curr_q <= curr_q;
            endcase
        end
    end

endmodule

// File: rtl/xct_irq_latch.sv
// Module: xct_irq_latch
// Sticky interrupt flag: set by a wrap, cleared by an acknowledge.
// Assumes: a set in the same cycle as an acknowledge wins.
module xct_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic flag_q
);
    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (ack_i) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/xfer_count_tracker.sv
// Module: xfer_count_tracker (top)
// Tracks circular DMA buffer progress in groups of bytes. The current
// count steps down once per group, and the group after zero reloads the
// count from the base and raises a sticky interrupt.
// Assumes: the host touches the counts only while run_en is low.
module xfer_count_tracker
    import xct_pkg::*;
#(
    parameter int COUNT_W     = 16,
    parameter int GROUP_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               byte_stb,
    input  logic               wr_base,
    input  logic               wr_curr,
    input  logic [COUNT_W-1:0] wr_data,
    input  logic               irq_ack,
    output logic [COUNT_W-1:0] base_count,
    output logic [COUNT_W-1:0] curr_count,
    output logic               irq_flag
);
    logic     grp_done;
    logic     curr_zero;
    logic     base_load;
    logic     wrap;
    cnt_act_e curr_act;

    xct_byte_grouper #(.GROUP_BYTES(GROUP_BYTES)) u_grouper (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .byte_stb (byte_stb),
        .grp_done (grp_done)
    );

    xct_count_ctrl u_ctrl (
        .run_en    (run_en),
        .grp_done  (grp_done),
        .curr_zero (curr_zero),
        .wr_base   (wr_base),
        .wr_curr   (wr_curr),
        .curr_act  (curr_act),
        .base_load (base_load),
        .wrap      (wrap)
    );

    xct_count_regs #(.COUNT_W(COUNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .curr_act  (curr_act),
        .base_load (base_load),
        .wr_data   (wr_data),
        .base_q    (base_count),
        .curr_q    (curr_count),
        .curr_zero (curr_zero)
    );

    xct_irq_latch u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wrap),
        .ack_i  (irq_ack),
        .flag_q (irq_flag)
    );

endmodule

// File: rtl/xfer_count_tracker_chk.sv
// Module: xfer_count_tracker_chk
// Port-level temporal checks for xfer_count_tracker, attached by bind.
module xfer_count_tracker_chk #(
    parameter int COUNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_en,
    input logic               byte_stb,
    input logic               wr_base,
    input logic               wr_curr,
    input logic [COUNT_W-1:0] wr_data,
    input logic               irq_ack,
    input logic [COUNT_W-1:0] base_count,
    input logic [COUNT_W-1:0] curr_count,
    input logic               irq_flag
);
    // R2: accepted base write lands in both counts.
    p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && wr_base) |=>
            (base_count == $past(wr_data) && curr_count == $past(wr_data)));

    // R3: current-only write leaves base unchanged.
    p_curr_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && wr_curr && !wr_base) |=>
            (curr_count == $past(wr_data) && $stable(base_count)));

    // R4: without a strobe the current count does not move while enabled.
    p_no_stb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !byte_stb) |=> $stable(curr_count));

    // R5: a newly raised flag coincides with a reloaded count.
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> (curr_count == base_count));

    // R6: base never changes while enabled.
    p_base_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> $stable(base_count));

    // R8: disabled and no host write means nothing moves.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_base && !wr_curr) |=>
            ($stable(curr_count) && $stable(base_count)));

    // R9: flag stays up until acknowledged.
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_ack) |=> irq_flag);

    // R9: flag can only rise while enabled.
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !irq_flag) |=> !irq_flag);

endmodule

bind xfer_count_tracker xfer_count_tracker_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .byte_stb   (byte_stb),
    .wr_base    (wr_base),
    .wr_curr    (wr_curr),
    .wr_data    (wr_data),
    .irq_ack    (irq_ack),
    .base_count (base_count),
    .curr_count (curr_count),
    .irq_flag   (irq_flag)
);

// File: tb/xfer_count_tracker_bench.sv
// Bench for xfer_count_tracker: directed corners plus seeded random
// stimulus, compared against a cycle model held in bench state.
module xfer_count_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic         byte_stb = 1'b0;
    logic         wr_base = 1'b0;
    logic         wr_curr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         irq_ack = 1'b0;
    logic [W-1:0] base_count;
    logic [W-1:0] curr_count;
    logic         irq_flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [W-1:0] m_base = '0;
    logic [W-1:0] m_curr = '0;
    logic [1:0]   m_pos = '0;
    logic         m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_count_tracker u_xfer_count_tracker (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .byte_stb(byte_stb),
        .wr_base(wr_base), .wr_curr(wr_curr), .wr_data(wr_data),
        .irq_ack(irq_ack), .base_count(base_count),
        .curr_count(curr_count), .irq_flag(irq_flag)
    );

    // Expected next current count for one cycle of stimulus.
    function automatic logic [W-1:0] exp_curr(input logic en, input logic stb,
            input logic wb, input logic wc, input logic [W-1:0] d);
        if (!en) return (wb || wc) ? d : m_curr;
        if (stb && m_pos == 2'd3) return (m_curr == '0) ? m_base : m_curr - 1'b1;
        return m_curr;
    endfunction

    // Expected next flag for one cycle of stimulus.
    function automatic logic exp_irq(input logic en, input logic stb,
            input logic ack);
        if (en && stb && m_pos == 2'd3 && m_curr == '0) return 1'b1;
        if (ack) return 1'b0;
        return m_irq;
    endfunction

    task automatic check(input string req, input string what,
            input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model, compare at next negedge.
    task automatic step(input string req, input logic en, input logic stb,
            input logic wb, input logic wc, input logic [W-1:0] d,
            input logic ack);
        logic [W-1:0] nc;
        logic         ni;
        run_en = en; byte_stb = stb; wr_base = wb; wr_curr = wc;
        wr_data = d; irq_ack = ack;
        nc = exp_curr(en, stb, wb, wc, d);
        ni = exp_irq(en, stb, ack);
        if (!en && wb) m_base = d;
        if (!en) m_pos = 2'd0;
        else if (stb) m_pos = m_pos + 2'd1;
        m_curr = nc;
        m_irq = ni;
        @(negedge clk);
        check(req, "base", base_count, m_base);
        check(req, "curr", curr_count, m_curr);
        check(req, "irq", {15'd0, irq_flag}, {15'd0, m_irq});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "base", base_count, 16'h0);
        check("R1", "curr", curr_count, 16'h0);
        check("R1", "irq", {15'd0, irq_flag}, 16'h0);
        // R2 base write loads both
        step("R2", 0, 0, 1, 0, 16'd2, 0);
        // R3 current-only write
        step("R3", 0, 0, 0, 1, 16'd1, 0);
        // R8 strobes while disabled do nothing
        for (int i = 0; i < 5; i++) step("R8", 0, 1, 0, 0, 16'h0, 0);
        // R4 three strobes hold, fourth decrements to 0
        for (int i = 0; i < 4; i++) step("R4", 1, 1, 0, 0, 16'h0, 0);
        // R6 writes while enabled ignored
        step("R6", 1, 0, 1, 0, 16'h1234, 0);
        step("R6", 1, 0, 0, 1, 16'h4321, 0);
        // R5 group after zero reloads base (2) and sets irq
        for (int i = 0; i < 4; i++) step("R5", 1, 1, 0, 0, 16'h0, 0);
        // R9 flag sticky, then ack clears
        step("R9", 1, 0, 0, 0, 16'h0, 0);
        step("R9", 1, 0, 0, 0, 16'h0, 1);
        // R7 partial group then disable and re-enable
        for (int i = 0; i < 3; i++) step("R7", 1, 1, 0, 0, 16'h0, 0);
        step("R7", 0, 0, 0, 0, 16'h0, 0);
        for (int i = 0; i < 3; i++) step("R7", 1, 1, 0, 0, 16'h0, 0);
        step("R7", 1, 1, 0, 0, 16'h0, 0);
        // R9 wrap and ack in the same cycle: set wins
        step("R9", 0, 0, 1, 0, 16'h0, 0);
        for (int i = 0; i < 3; i++) step("R9", 1, 1, 0, 0, 16'h0, 0);
        step("R9", 1, 1, 0, 0, 16'h0, 1);
        // Random mix, exercising R2 R3 R4 R5 R6 R7 R8 R9
        begin
            logic en = 1'b0;
            for (int i = 0; i < 4000; i++) begin
                logic stb, wb, wc, ack;
                logic [W-1:0] d;
                if ($urandom_range(0, 39) == 0) en = ~en;
                stb = ($urandom_range(0, 2) != 0);
                wb  = ($urandom_range(0, 5) == 0);
                wc  = ($urandom_range(0, 5) == 0);
                ack = ($urandom_range(0, 9) == 0);
                d   = W'($urandom_range(0, 4));
                step("R4", en, stb, wb, wc, d, ack);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule